// File: doc/BRIEF.md
# Host Bridge Configuration Space with Shadow Memory Routing

This block holds the 256-byte configuration register space of a memory-controller host bridge. Software reads and writes it one byte at a time through a configuration port that carries a function number and a register offset. A fixed set of offsets is read-only identification. A few offsets mask or force bits on write. Every other offset stores the written byte exactly as it was written.

Seven of the registers are shadow attribute registers. Each holds 4-bit fields, and each field decides where accesses to one part of the legacy window 0xC0000 to 0xFFFFF are sent. Reads and writes are routed separately, either to local DRAM or to the expansion bus. A memory query port takes a 20-bit address and a read/write flag, and returns the routing decision combinationally from the current register contents. A bus-reset pulse turns off shadowing of the top 64 KB. A status output shows whether the BIOS region is shadowed for reads.

Top module: `host_bridge_cfg`

## Requirements
- R1: When `cfgFunc` is not 0, a write leaves every register unchanged and `cfgRdata` reads 0xFF.
- R2: After reset, every offset reads 0x00 except the following: 0x00=0x86, 0x01=0x80, 0x02=0x30, 0x03=0x70, 0x04=0x06, 0x07=0x02, 0x0B=0x06, 0x52=0x42, 0x53=0x14, 0x56=0x52, 0x57=0x01, 0x60 through 0x64=0x02, 0x67=0x11, 0x69=0x03, 0x70=0x20, 0x72=0x02, 0x74=0x0E, 0x78=0x23.
- R3: Writes to offsets 0x00–0x03, 0x08–0x0C, 0x0E and 0x10–0x4E have no effect.
- R4: A write to offset 0x04 stores (data & 0x02) | 0x04. Writes to 0x05 and 0x06 store 0x00.
- R5: A write to offset 0x07 stores (data & 0x80) | 0x02.
- R6: Every offset not named in R3–R5 stores the written byte unmodified and reads it back exactly.
- R7: In an attribute field, bit 0 set sends reads to local DRAM and bit 1 set sends writes to local DRAM. A clear bit sends that direction to the expansion bus. `memLocal`=1 means local DRAM and `memLocal`=0 means the expansion bus.
- R8: Bits 7:4 of offset 0x59 control 0xF0000–0xFFFFF. `shadowBios` equals bit 4 of offset 0x59.
- R9: Offset 0x5A+k, for k = 0 to 5, controls the 16 KB segments at 0xC0000+k·0x8000 (bits 3:0) and at 0xC4000+k·0x8000 (bits 7:4).
- R10: A `busRst` pulse writes 0x00 to offset 0x59. When a configuration write arrives in the same cycle, the pulse takes precedence over it, and no other register changes.
- R11: Addresses below 0xC0000 route to local DRAM for both reads and writes.
- R12: A write takes effect at the clock edge, so a query or read in the next cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busRst | input | 1 | Bus-reset pulse; clears the top shadow register |
| cfgFunc | input | 3 | Function number of the configuration access |
| cfgAddr | input | 8 | Register offset |
| cfgWe | input | 1 | Write enable |
| cfgWdata | input | 8 | Write data |
| cfgRdata | output | 8 | Read data (combinational) |
| memAddr | input | 20 | Memory query address |
| memWrite | input | 1 | 1 = query for a write, 0 = query for a read |
| memLocal | output | 1 | 1 = local DRAM, 0 = expansion bus |
| shadowBios | output | 1 | BIOS region read-shadow status |

## Verification
A corrupted register shows up as a wrong value on `cfgRdata` in the cycle that offset is read. A corrupted attribute field flips `memLocal` at once for every address in its segment and for one access direction. Faults in segment indexing or nibble selection are therefore found by querying every segment in both directions, with distinct settings in the low and high fields. A bus-reset fault shows up one cycle after the pulse, on `shadowBios` and on the routing of 0xF0000.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  localparam int CFG_AW = 8;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              wrEn;
    logic [CFG_AW-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
  } cfgStrobe_t;

  function automatic logic [DATA_W-1:0] resetValue(input logic [CFG_AW-1:0] a);
    case (a)
      8'h00: return 8'h86;
      8'h01: return 8'h80;
      8'h02: return 8'h30;
      8'h03: return 8'h70;
      8'h04: return 8'h06;
      8'h07: return 8'h02;
      8'h0B: return 8'h06;
      8'h52: return 8'h42;
      8'h53: return 8'h14;
      8'h56: return 8'h52;
      8'h57: return 8'h01;
      8'h60, 8'h61, 8'h62, 8'h63, 8'h64: return 8'h02;
      8'h67: return 8'h11;
      8'h69: return 8'h03;
      8'h70: return 8'h20;
      8'h72: return 8'h02;
      8'h74: return 8'h0E;
      8'h78: return 8'h23;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hbc_ctrl.sv
module hbc_ctrl
  import hbc_pkg::*;
#(
  parameter int FUNC_W = 3,
  parameter logic [CFG_AW-1:0] TOP_ATTR = 8'h59
) (
  input  logic              busRst,
  input  logic [FUNC_W-1:0] cfgFunc,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgWe,
  input  logic [DATA_W-1:0] cfgWdata,
  output cfgStrobe_t        strobe
);
  logic readOnly;

  always_comb begin
    readOnly = (cfgAddr <= 8'h03) ||
               (cfgAddr >= 8'h08 && cfgAddr <= 8'h0C) ||
               (cfgAddr == 8'h0E) ||
               (cfgAddr >= 8'h10 && cfgAddr <= 8'h4E);
  end

  always_comb begin
    strobe = '0;
    if (busRst) begin
      strobe.wrEn   = 1'b1;
      strobe.wrAddr = TOP_ATTR;
      strobe.wrData = '0;
    end else if (cfgWe && cfgFunc == '0 && !readOnly) begin
      strobe.wrEn   = 1'b1;
      strobe.wrAddr = cfgAddr;
      case (cfgAddr)
        8'h04:        strobe.wrData = (cfgWdata & 8'h02) | 8'h04;
        8'h05, 8'h06: strobe.wrData = 8'h00;
        8'h07:        strobe.wrData = (cfgWdata & 8'h80) | 8'h02;
        default:      strobe.wrData = cfgWdata;
      endcase
    end
  end
endmodule

// File: rtl/hbc_regs.sv
module hbc_regs
  import hbc_pkg::*;
#(
  parameter int MEM_AW  = 20,
  parameter int SEG_LSB = 14,
  parameter logic [CFG_AW-1:0] TOP_ATTR  = 8'h59,
  parameter logic [CFG_AW-1:0] ATTR_BASE = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  cfgStrobe_t        strobe,
  input  logic [CFG_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic              memWrite,
  output logic              memLocal,
  output logic              shadowBios
);
  localparam int NUM_REGS = 1 << CFG_AW;
  localparam int TOP_BIT  = MEM_AW - 1;
  localparam int SEG_W    = MEM_AW - 2 - SEG_LSB;

  logic [DATA_W-1:0] regFile [0:NUM_REGS-1];
  logic              inWindow, inTop;
  logic [SEG_W-1:0]  segIdx;
  logic [CFG_AW-1:0] attrReg;
  logic [3:0]        attrNib;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= resetValue(CFG_AW'(i));
    end else if (strobe.wrEn) begin
      regFile[strobe.wrAddr] <= strobe.wrData;
    end
  end

  assign rdData     = regFile[rdAddr];
  assign shadowBios = regFile[TOP_ATTR][4];

  always_comb begin
    inWindow = memAddr[TOP_BIT -: 2] == 2'b11;
    inTop    = memAddr[TOP_BIT -: 4] == 4'hF;
    segIdx   = memAddr[SEG_LSB +: SEG_W];
    attrReg  = ATTR_BASE + CFG_AW'(segIdx >> 1);
    if (inTop)          attrNib = regFile[TOP_ATTR][7:4];
    else if (segIdx[0]) attrNib = regFile[attrReg][7:4];
    else                attrNib = regFile[attrReg][3:0];
    if (!inWindow)      memLocal = 1'b1;
    else                memLocal = memWrite ? attrNib[1] : attrNib[0];
  end

  // R2, R3: identification bytes never move after reset
  a_r3_id_locked: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> regFile[8'h00] == 8'h86 && regFile[8'h01] == 8'h80 &&
             regFile[8'h02] == 8'h30 && regFile[8'h03] == 8'h70);
  // R4: command byte keeps only bit 1, bit 2 always set
  a_r4_cmd_mask: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (regFile[8'h04] & 8'hF9) == 8'h00 && regFile[8'h04][2]);
  // R5: status high byte keeps only bit 7, bit 1 always set
  a_r5_stat_mask: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (regFile[8'h07] & 8'h7D) == 8'h00 && regFile[8'h07][1]);
  // R11: below the legacy window everything is local
  a_r11_outside_local: assert property (@(posedge clk) disable iff (rst)
    memAddr[TOP_BIT -: 2] != 2'b11 |-> memLocal);
endmodule

// File: rtl/host_bridge_cfg.sv
module host_bridge_cfg
  import hbc_pkg::*;
#(
  parameter int FUNC_W = 3,
  parameter int MEM_AW = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busRst,
  input  logic [FUNC_W-1:0] cfgFunc,
  input  logic [7:0]        cfgAddr,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic              memWrite,
  output logic              memLocal,
  output logic              shadowBios
);
  cfgStrobe_t        strobe;
  logic [DATA_W-1:0] regData;

  hbc_ctrl #(.FUNC_W(FUNC_W)) u_ctrl (
    .busRst(busRst), .cfgFunc(cfgFunc), .cfgAddr(cfgAddr),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .strobe(strobe)
  );

  hbc_regs #(.MEM_AW(MEM_AW)) u_regs (
    .clk(clk), .rst(rst), .strobe(strobe), .rdAddr(cfgAddr),
    .rdData(regData), .memAddr(memAddr), .memWrite(memWrite),
    .memLocal(memLocal), .shadowBios(shadowBios)
  );

  assign cfgRdata = (cfgFunc == '0) ? regData : 8'hFF;

  // R1: other functions never produce a register write
  a_r1_func_no_write: assert property (@(posedge clk) disable iff (rst)
    (cfgWe && cfgFunc != '0 && !busRst) |-> !strobe.wrEn);
  // R10: a bus-reset pulse drops BIOS shadowing on the next cycle
  a_r10_busrst_clears: assert property (@(posedge clk) disable iff (rst)
    busRst |=> !shadowBios);
endmodule

// File: tb/host_bridge_cfg_tb.sv
module host_bridge_cfg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busRst = 1'b0;
  logic [2:0]  cfgFunc = '0;
  logic [7:0]  cfgAddr = '0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic [19:0] memAddr = '0;
  logic        memWrite = 1'b0;
  logic        memLocal;
  logic        shadowBios;

  int testCount = 0;
  int failCount = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  host_bridge_cfg u_dut (
    .clk(clk), .rst(rst), .busRst(busRst), .cfgFunc(cfgFunc), .cfgAddr(cfgAddr),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .memAddr(memAddr),
    .memWrite(memWrite), .memLocal(memLocal), .shadowBios(shadowBios)
  );

  // {write function, offset, write data, expected read-back on function 0}
  localparam int NVEC = 18;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h00_04_FF_06, 32'h00_04_00_04, 32'h00_05_FF_00, 32'h00_06_FF_00,
    32'h00_07_FF_82, 32'h00_07_7D_02, 32'h00_00_12_86, 32'h00_0B_FF_06,
    32'h00_0C_77_00, 32'h00_0E_33_00, 32'h00_20_AA_00, 32'h00_4E_55_00,
    32'h00_0D_77_77, 32'h00_0F_44_44, 32'h00_4F_5A_5A, 32'h00_80_C3_C3,
    32'h01_50_99_00, 32'h07_0D_11_77
  };

  function automatic logic [7:0] expReset(input int a);
    if (a >= 8'h60 && a <= 8'h64) return 8'h02;
    case (a)
      8'h00: return 8'h86; 8'h01: return 8'h80; 8'h02: return 8'h30;
      8'h03: return 8'h70; 8'h04: return 8'h06; 8'h07: return 8'h02;
      8'h0B: return 8'h06; 8'h52: return 8'h42; 8'h53: return 8'h14;
      8'h56: return 8'h52; 8'h57: return 8'h01; 8'h67: return 8'h11;
      8'h69: return 8'h03; 8'h70: return 8'h20; 8'h72: return 8'h02;
      8'h74: return 8'h0E; 8'h78: return 8'h23;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgFunc = f; cfgAddr = a; cfgWdata = d; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0; cfgFunc = '0;
  endtask

  task automatic cfgRead(input logic [2:0] f, input logic [7:0] a, output logic [7:0] d);
    cfgFunc = f; cfgAddr = a;
    #1 d = cfgRdata;
    cfgFunc = '0;
  endtask

  task automatic query(input logic [19:0] a, input logic w, output logic loc);
    memAddr = a; memWrite = w;
    #1 loc = memLocal;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      testCount++; failCount++;
      $display("FAIL watchdog: actual %0d expected <100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic loc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset image
    for (int a = 0; a < 256; a++) begin
      cfgRead(3'd0, 8'(a), rd);
      check("R2 reset value", rd, expReset(a));
    end
    check("R8 shadowBios after reset", shadowBios, 1'b0);

    // R1 R3 R4 R5 R6 R12 vector table
    for (int i = 0; i < NVEC; i++) begin
      cfgWrite(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8]);
      cfgRead(3'd0, VEC[i][23:16], rd);
      check("R1/R3/R4/R5/R6 write-readback", {VEC[i][23:16], rd}, {VEC[i][23:16], VEC[i][7:0]});
    end
    cfgRead(3'd1, 8'h00, rd);  check("R1 func1 read", rd, 8'hFF);
    cfgRead(3'd5, 8'h0D, rd);  check("R1 func5 read", rd, 8'hFF);

    // R7 R8 top region
    cfgWrite(3'd0, 8'h59, 8'h10);
    check("R8 shadowBios set", shadowBios, 1'b1);
    query(20'hF0000, 1'b0, loc); check("R7 R8 top read local", loc, 1'b1);
    query(20'hFFFFF, 1'b1, loc); check("R7 R8 top write bus", loc, 1'b0);
    cfgWrite(3'd0, 8'h59, 8'h2F);
    check("R8 shadowBios clear", shadowBios, 1'b0);
    query(20'hF8000, 1'b0, loc); check("R7 R8 top read bus", loc, 1'b0);
    query(20'hF8000, 1'b1, loc); check("R7 R8 top write local", loc, 1'b1);

    // R9 every segment, low field = read-only (1), high field = write-only (2)
    for (int k = 0; k < 6; k++) cfgWrite(3'd0, 8'(8'h5A + k), 8'h21);
    for (int s = 0; s < 12; s++) begin
      logic [19:0] base = 20'hC0000 + 20'(s) * 20'h4000;
      logic expR = (s % 2 == 0);
      query(base + 20'h1234, 1'b0, loc); check("R9 segment read", {8'(s), 7'd0, loc}, {8'(s), 7'd0, expR});
      query(base + 20'h3FFF, 1'b1, loc); check("R9 segment write", {8'(s), 7'd0, loc}, {8'(s), 7'd0, !expR});
    end
    cfgWrite(3'd0, 8'h5F, 8'h30);
    query(20'hE8000, 1'b0, loc); check("R9 0x5F low both bus", loc, 1'b0);
    query(20'hEC000, 1'b1, loc); check("R9 0x5F high write local", loc, 1'b1);
    query(20'hEFFFF, 1'b0, loc); check("R9 0x5F high read local", loc, 1'b1);

    // R11 outside window
    query(20'h00000, 1'b0, loc); check("R11 low read", loc, 1'b1);
    query(20'hBFFFF, 1'b1, loc); check("R11 edge write", loc, 1'b1);
    query(20'h80000, 1'b1, loc); check("R11 mid write", loc, 1'b1);

    // R10 bus reset
    cfgWrite(3'd0, 8'h59, 8'h33);
    @(negedge clk); busRst = 1'b1; @(negedge clk); busRst = 1'b0;
    cfgRead(3'd0, 8'h59, rd); check("R10 busRst clears 0x59", rd, 8'h00);
    check("R10 shadowBios off", shadowBios, 1'b0);
    query(20'hF0000, 1'b0, loc); check("R10 top read bus", loc, 1'b0);
    cfgRead(3'd0, 8'h5F, rd); check("R10 other reg kept", rd, 8'h30);
    @(negedge clk);
    cfgFunc = 3'd0; cfgAddr = 8'h59; cfgWdata = 8'h33; cfgWe = 1'b1; busRst = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0; busRst = 1'b0;
    cfgRead(3'd0, 8'h59, rd); check("R10 busRst beats write", rd, 8'h00);
    @(negedge clk);
    cfgFunc = 3'd0; cfgAddr = 8'h80; cfgWdata = 8'h5C; cfgWe = 1'b1; busRst = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0; busRst = 1'b0;
    cfgRead(3'd0, 8'h80, rd); check("R10 concurrent write dropped", rd, 8'hC3);

    // R2 reset again restores image
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    cfgRead(3'd0, 8'h04, rd); check("R2 re-reset 0x04", rd, 8'h06);
    cfgRead(3'd0, 8'h5A, rd); check("R2 re-reset 0x5A", rd, 8'h00);
    cfgRead(3'd0, 8'h80, rd); check("R2 re-reset 0x80", rd, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule